// File: doc/BRIEF.md
# Transmit FIFO Request and Start Controller

This block sits between a transmit byte FIFO and the medium access controller. From the FIFO's fill and free-space counts it drives a request line. The request asks the host-side transfer engine for more bytes. It is raised when enough space has opened up, and it is always raised while the FIFO is empty. The block also decides when the transmitter may start sending preamble: either once a programmable number of bytes is buffered, or at once when the last byte of the frame has already been written.

All pins are plain control and status levels or pulses. No data flows through the block, so it has no valid/ready handshake. The inputs are sampled on the rising clock edge. Both outputs are registered and change one clock after the inputs that cause them. A start pulse is issued once per frame. After that the block waits for the controller to report the frame as finished before it can start again.

Top module: `txq_ctrl`

## Requirements
- R1: `xfer_req` is high only while `xmit_en` is set. If `xmit_en` is low at a rising edge, `xfer_req` is low after that edge.
- R2: With `xmit_en` set and `fifo_fill` equal to 0, `xfer_req` is high after the next edge, whatever `wm_sel` holds.
- R3: With `xmit_en` set, `xfer_req` is high after the next edge when `fifo_free` is at least the watermark. The watermark is 16 bytes for `wm_sel`=00, 32 bytes for 01, and 64 bytes for 10 or 11.
- R4: With `fifo_fill` non-zero and `fifo_free` below the watermark, `xfer_req` is low after the next edge.
- R5: While armed and enabled, `tx_start` pulses one clock after `fifo_fill` reaches the start point. The start point is 4 bytes for `sp_sel`=00, 16 for 01, 64 for 10 and 112 for 11.
- R6: A `last_wr` pulse while armed lets transmission start before the start point is reached. It starts at the first edge at which `xmit_en` is set and `fifo_fill` is non-zero, and the pulse is remembered until then.
- R7: `tx_start` lasts exactly one cycle. Further pulses are not issued for the same frame, and a `last_wr` pulse seen after the start is ignored.
- R8: A `tx_done` pulse re-arms the block, so the next frame can produce a new `tx_start`. On the edge where `tx_done` is seen, no start is issued.
- R9: `tx_start` is never issued while `xmit_en` is low. The pending start is held until enable returns.
- R10: After reset, `xfer_req` and `tx_start` are low and the block is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| xmit_en | input | 1 | Transmit enable |
| fifo_fill | input | CNT_W | Bytes held in the transmit FIFO |
| fifo_free | input | CNT_W | Free byte slots in the transmit FIFO |
| wm_sel | input | 2 | Request watermark select |
| sp_sel | input | 2 | Start-point select |
| last_wr | input | 1 | Pulse: last byte of the frame written |
| tx_done | input | 1 | Pulse: frame transmission finished |
| xfer_req | output | 1 | Transfer request to the host side |
| tx_start | output | 1 | One-cycle start-transmission pulse |

## Verification
If the armed state were wrong, the error would show within one clock of the relevant input. A stuck-armed block would give a second `tx_start` in the cycle right after the first. A block that failed to re-arm would give no pulse one clock after the next frame crosses its start point. A wrong watermark or start-point decode would show as `xfer_req` or `tx_start` taking the wrong value one clock after the count crosses the boundary. The stimulus therefore sits exactly on each boundary. If the remembered last-write flag were lost, the pulse would be missing in the cycle after enable returns.

// File: rtl/txq_pkg.sv
package txq_pkg;
  // Request watermark in free bytes: 00 -> 16, 01 -> 32, 1x -> 64
  function automatic int unsigned wm_bytes(input logic [1:0] sel);
    case (sel)
      2'b00:   return 16;
      2'b01:   return 32;
      default: return 64;
    endcase
  endfunction

  // Start point in buffered bytes: 00 -> 4, 01 -> 16, 10 -> 64, 11 -> 112
  function automatic int unsigned sp_bytes(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4;
      2'b01:   return 16;
      2'b10:   return 64;
      default: return 112;
    endcase
  endfunction

  typedef enum logic {ST_ARMED = 1'b0, ST_SENT = 1'b1} start_state_e;
endpackage

// File: rtl/txq_req_gen.sv
module txq_req_gen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xmit_en,
  input  logic [CNT_W-1:0] fifo_fill,
  input  logic [CNT_W-1:0] fifo_free,
  input  logic [1:0]       wm_sel,
  output logic             xfer_req
);
  logic [CNT_W-1:0] wm_lvl;
  logic             req_d;

  always_comb begin
    wm_lvl = CNT_W'(txq_pkg::wm_bytes(wm_sel));
    req_d  = xmit_en && ((fifo_fill == '0) || (fifo_free >= wm_lvl));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xfer_req <= 1'b0;
    else        xfer_req <= req_d;
  end

  assert_req_drops_when_disabled_R1: assert property (
    @(posedge clk) disable iff (!rst_n) !xmit_en |=> !xfer_req);

  assert_req_forced_when_empty_R2: assert property (
    @(posedge clk) disable iff (!rst_n) (xmit_en && fifo_fill == '0) |=> xfer_req);
endmodule

// File: rtl/txq_start_ctl.sv
module txq_start_ctl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xmit_en,
  input  logic [CNT_W-1:0] fifo_fill,
  input  logic [1:0]       sp_sel,
  input  logic             last_wr,
  input  logic             tx_done,
  output logic             tx_start
);
  import txq_pkg::*;

  start_state_e     state_q;
  logic             last_seen_q;
  logic [CNT_W-1:0] sp_lvl;
  logic             go;

  always_comb begin
    sp_lvl = CNT_W'(sp_bytes(sp_sel));
    go     = (state_q == ST_ARMED) && !tx_done && xmit_en && (fifo_fill != '0) &&
             ((fifo_fill >= sp_lvl) || last_wr || last_seen_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_ARMED;
      last_seen_q <= 1'b0;
      tx_start    <= 1'b0;
    end else begin
      tx_start <= go;
      if (tx_done) begin
        state_q     <= ST_ARMED;
        last_seen_q <= 1'b0;
      end else if (go) begin
        state_q     <= ST_SENT;
        last_seen_q <= 1'b0;
      end else if (state_q == ST_ARMED && last_wr) begin
        last_seen_q <= 1'b1;
      end
    end
  end

  assert_start_one_cycle_R7: assert property (
    @(posedge clk) disable iff (!rst_n) tx_start |=> !tx_start);

  assert_start_needs_enable_R9: assert property (
    @(posedge clk) disable iff (!rst_n) tx_start |-> $past(xmit_en));

  assert_start_at_threshold_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED && !tx_done && xmit_en && fifo_fill != '0 && fifo_fill >= sp_lvl)
    |=> tx_start);

  assert_no_start_on_done_R8: assert property (
    @(posedge clk) disable iff (!rst_n) tx_done |=> !tx_start);
endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl #(
  parameter int FIFO_DEPTH = 128,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xmit_en,
  input  logic [CNT_W-1:0] fifo_fill,
  input  logic [CNT_W-1:0] fifo_free,
  input  logic [1:0]       wm_sel,
  input  logic [1:0]       sp_sel,
  input  logic             last_wr,
  input  logic             tx_done,
  output logic             xfer_req,
  output logic             tx_start
);
  txq_req_gen #(.CNT_W(CNT_W)) u_req (
    .clk(clk), .rst_n(rst_n), .xmit_en(xmit_en),
    .fifo_fill(fifo_fill), .fifo_free(fifo_free), .wm_sel(wm_sel),
    .xfer_req(xfer_req)
  );

  txq_start_ctl #(.CNT_W(CNT_W)) u_start (
    .clk(clk), .rst_n(rst_n), .xmit_en(xmit_en),
    .fifo_fill(fifo_fill), .sp_sel(sp_sel), .last_wr(last_wr),
    .tx_done(tx_done), .tx_start(tx_start)
  );
endmodule

// File: tb/txq_ctrl_tb.sv
module txq_ctrl_tb;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             xmit_en = 1'b0;
  logic [CNT_W-1:0] fifo_fill = '0;
  logic [CNT_W-1:0] fifo_free = 8'd128;
  logic [1:0]       wm_sel = 2'b00;
  logic [1:0]       sp_sel = 2'b00;
  logic             last_wr = 1'b0;
  logic             tx_done = 1'b0;
  logic             xfer_req;
  logic             tx_start;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic  req;
    logic  start;
    string tag;
  } exp_t;
  exp_t expq[$];

  always #5 clk = ~clk;

  txq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .xmit_en(xmit_en),
    .fifo_fill(fifo_fill), .fifo_free(fifo_free), .wm_sel(wm_sel),
    .sp_sel(sp_sel), .last_wr(last_wr), .tx_done(tx_done),
    .xfer_req(xfer_req), .tx_start(tx_start)
  );

  // Monitor: one expected item per edge, sampled 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (expq.size() > 0) begin
      exp_t e;
      e = expq.pop_front();
      checks++;
      if (xfer_req !== e.req || tx_start !== e.start) begin
        fails++;
        $display("FAIL %s: req/start actual %b%b expected %b%b",
                 e.tag, xfer_req, tx_start, e.req, e.start);
      end
    end
  end

  // Driver: apply inputs at the falling edge, queue the result due after the next rising edge
  task automatic step(input logic en, input int fill, input logic [1:0] wm,
                      input logic [1:0] sp, input logic lw, input logic dn,
                      input logic ereq, input logic est, input string tag);
    @(negedge clk);
    xmit_en   = en;
    fifo_fill = CNT_W'(fill);
    fifo_free = CNT_W'(128 - fill);
    wm_sel    = wm;
    sp_sel    = sp;
    last_wr   = lw;
    tx_done   = dn;
    expq.push_back('{ereq, est, tag});
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (xfer_req !== 1'b0 || tx_start !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: actual %b%b expected 00", xfer_req, tx_start);
    end
    @(negedge clk);
    rst_n = 1'b1;

    step(0,   0, 2'd2, 2'd3, 0, 0, 0, 0, "R1 disabled empty");
    step(1,   0, 2'd2, 2'd3, 0, 0, 1, 0, "R2 empty forces req");
    step(1,  10, 2'd2, 2'd3, 0, 0, 1, 0, "R3 free118 wm64");
    step(1,  70, 2'd2, 2'd3, 0, 0, 0, 0, "R4 free58 wm64");
    step(1,  70, 2'd1, 2'd3, 0, 0, 1, 0, "R3 free58 wm32");
    step(1, 100, 2'd1, 2'd3, 0, 0, 0, 0, "R4 free28 wm32");
    step(1, 100, 2'd0, 2'd3, 0, 0, 1, 0, "R3 free28 wm16");
    step(1, 112, 2'd0, 2'd3, 0, 0, 1, 1, "R5 start point 112, R3 free16");
    step(1, 112, 2'd0, 2'd3, 0, 0, 1, 0, "R7 single pulse");
    step(1, 112, 2'd0, 2'd3, 1, 0, 1, 0, "R7 last_wr after start ignored");
    step(1,   0, 2'd0, 2'd0, 0, 1, 1, 0, "R8 no start on done");
    step(1,   0, 2'd0, 2'd0, 0, 0, 1, 0, "R5 empty no start");
    step(1,   3, 2'd0, 2'd0, 0, 0, 1, 0, "R5 below start point 4");
    step(1,   4, 2'd0, 2'd0, 0, 0, 1, 1, "R5 start point 4, R8 re-armed");
    step(1,   0, 2'd0, 2'd0, 0, 1, 1, 0, "R8 done");
    step(1,   2, 2'd0, 2'd2, 1, 0, 1, 1, "R6 last byte early start");
    step(1,   0, 2'd0, 2'd2, 0, 1, 1, 0, "R8 done");
    step(0,   5, 2'd0, 2'd1, 1, 0, 0, 0, "R9 R1 disabled with last_wr");
    step(0,   5, 2'd0, 2'd1, 0, 0, 0, 0, "R9 start held");
    step(1,   5, 2'd0, 2'd1, 0, 0, 1, 1, "R6 R9 remembered last starts");
    step(1,   0, 2'd0, 2'd1, 0, 1, 1, 0, "R8 done");
    step(1,  16, 2'd0, 2'd1, 0, 0, 1, 1, "R5 start point 16");
    step(1,  16, 2'd0, 2'd1, 0, 0, 1, 0, "R7 once per frame");
    step(1,  64, 2'd3, 2'd2, 0, 0, 1, 0, "R3 wm11 is 64, free64");

    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule